// File: doc/BRIEF.md
# Three-phase NVM command sequencer

This block sits on the controller side of a non-volatile memory channel. It takes one request at a time and turns it into the command/address traffic for a device that addresses a row in three steps. First, a preactive command loads the upper row bits into a row address buffer. Second, an activate command supplies the lower row bits and pulls the row into the paired row data buffer. Third, a read or write command carries the column. The controller chooses the row-buffer pair on separate select lines, and that choice does not depend on the address. An external buffer manager tells the sequencer whether the target buffer already holds the row. On a hit, the first two phases are skipped. The manager can also ask for a prefetch, which fills a buffer without the final phase.

The sequencer enforces the minimum spacing between phases in memory clocks. Each clock carries 20 command/address bits, presented as a rising-edge word and a falling-edge word of 10 pins each. Once the access has run its course, a one-cycle done pulse returns the block to idle. A new request can be taken in that same cycle.

Top module: `nvm3p_seq`

## Requirements
- R1: After reset, both command words are zero (no-operation), `ca_ba` is 0, `done` and `busy` are 0 and `req_ready` is 1.
- R2: The command code sits in `ca_rise[9:7]`: 000 no-operation, 001 preactive, 010 activate, 011 read, 100 write. The 17-bit payload is `{ca_rise[6:0], ca_fall[9:0]}`, zero-extended. In every cycle with no command, the code and payload are zero and `ca_ba` is 0.
- R3: When a read or write is accepted without the hit hint, a preactive appears in the next cycle. Its payload is the upper row bits `req_row[ROW_W-1:ROW_LO_W]`.
- R4: The activate follows the preactive by exactly T_PRE_ACT (3) clocks. Its payload is the lower row bits `req_row[ROW_LO_W-1:0]`.
- R5: The read or write command follows the activate by exactly T_ACT_RW (48) clocks. Its payload is the column.
- R6: When a read or write is accepted with `req_hit`=1, the read or write command appears in the next cycle, and no preactive or activate is sent.
- R7: A prefetch request (`req_op[1]`=1) sends a preactive and an activate and no read or write. It ignores `req_hit`, and `done` rises T_ACT_RW clocks after the activate.
- R8: `done` is a one-cycle pulse. It comes RD_LAT (6) clocks after a read command, where `req_op`=00, or WR_LAT (3) clocks after a write command, where `req_op`=01. In the done cycle `busy` is 0 and `req_ready` is 1.
- R9: While `busy` is 1, `req_ready` is 0. Any request presented in that time is ignored and does not change the commands in progress.
- R10: On every command cycle, `ca_ba` carries the `req_buf` value of the request, whatever the row address is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_op | input | 2 | 00 read, 01 write, 1x prefetch |
| req_row | input | ROW_W (20) | Full row address |
| req_col | input | COL_W (5) | Column address |
| req_buf | input | BA_W (2) | Row-buffer pair to use |
| req_hit | input | 1 | Target buffer already holds the row |
| ca_rise | output | 10 | Command/address word for the rising edge |
| ca_fall | output | 10 | Command/address word for the falling edge |
| ca_ba | output | BA_W (2) | Row-buffer select during command cycles |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Request in progress |

## Verification
The assertions check on every cycle that no activate comes sooner than the preactive-to-activate gap, and that no read or write comes sooner than the activate-to-column gap. They also check that idle cycles carry zero code, zero payload and zero select, that an accepted request starts with a preactive or a column command, and that done is a single pulse that frees the block. Only the bench's scenarios can show the exact placement of each command: whether a hit skips the first two phases, whether a prefetch stops after the activate, the per-operation completion latency, and whether payload and select carry the right fields. The scenarios also show that a request held during busy leaves the traffic untouched.

// File: rtl/nvm3p_pkg.sv
`timescale 1ns/1ps
package nvm3p_pkg;

   localparam int CA_PINS   = 10;
   localparam int OPC_W     = 3;
   localparam int PAYLOAD_W = 2 * CA_PINS - OPC_W;

   typedef enum logic [OPC_W-1:0] {
      OPC_NOP = 3'b000,
      OPC_PRE = 3'b001,
      OPC_ACT = 3'b010,
      OPC_RD  = 3'b011,
      OPC_WR  = 3'b100
   } ca_opc_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_PRE_WAIT,
      ST_ACT_WAIT,
      ST_TAIL
   } seq_st_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/nvm3p_gap_timer.sv
`timescale 1ns/1ps
module nvm3p_gap_timer #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/nvm3p_ca_encoder.sv
`timescale 1ns/1ps
module nvm3p_ca_encoder
   import nvm3p_pkg::*;
#(
   parameter int ROW_W    = 20,
   parameter int ROW_LO_W = 8,
   parameter int COL_W    = 5
) (
   input  ca_opc_e            opc,
   input  logic [ROW_W-1:0]   row,
   input  logic [COL_W-1:0]   col,
   output logic [CA_PINS-1:0] rise,
   output logic [CA_PINS-1:0] fall
);

   localparam int ROW_HI_W = ROW_W - ROW_LO_W;

   logic [ROW_HI_W-1:0]  row_hi;
   logic [ROW_LO_W-1:0]  row_lo;
   logic [PAYLOAD_W-1:0] payload;

   assign row_hi = row[ROW_W-1:ROW_LO_W];
   assign row_lo = row[ROW_LO_W-1:0];

   always_comb begin
      case (opc)
         OPC_PRE:        payload = PAYLOAD_W'(row_hi);
         OPC_ACT:        payload = PAYLOAD_W'(row_lo);
         OPC_RD, OPC_WR: payload = PAYLOAD_W'(col);
         default:        payload = '0;
      endcase
   end

   assign rise = {opc, payload[PAYLOAD_W-1:CA_PINS]};
   assign fall = payload[CA_PINS-1:0];

endmodule

// File: rtl/nvm3p_seq.sv
`timescale 1ns/1ps
module nvm3p_seq
   import nvm3p_pkg::*;
#(
   parameter int NUM_BUF   = 4,
   parameter int ROW_W     = 20,
   parameter int ROW_LO_W  = 8,
   parameter int COL_W     = 5,
   parameter int T_PRE_ACT = 3,
   parameter int T_ACT_RW  = 48,
   parameter int RD_LAT    = 6,
   parameter int WR_LAT    = 3,
   localparam int BA_W     = $clog2(NUM_BUF)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [1:0]       req_op,
   input  logic [ROW_W-1:0] req_row,
   input  logic [COL_W-1:0] req_col,
   input  logic [BA_W-1:0]  req_buf,
   input  logic             req_hit,
   output logic [9:0]       ca_rise,
   output logic [9:0]       ca_fall,
   output logic [BA_W-1:0]  ca_ba,
   output logic             done,
   output logic             busy
);

   localparam int ROW_HI_W = ROW_W - ROW_LO_W;
   localparam int MAX_GAP  = imax(imax(T_PRE_ACT, T_ACT_RW), imax(RD_LAT, WR_LAT));
   localparam int CNT_W    = $clog2(MAX_GAP + 1);

   // elaboration-time parameter checks
   if (!(NUM_BUF == 4 || NUM_BUF == 8)) begin : g_bad_nbuf
      $error("nvm3p_seq: NUM_BUF must be 4 or 8");
   end
   if (ROW_LO_W < 1 || ROW_LO_W >= ROW_W) begin : g_bad_split
      $error("nvm3p_seq: ROW_LO_W must leave upper and lower row bits");
   end
   if (ROW_HI_W > PAYLOAD_W || ROW_LO_W > PAYLOAD_W || COL_W > PAYLOAD_W) begin : g_bad_payload
      $error("nvm3p_seq: address field wider than the command payload");
   end
   if (T_PRE_ACT < 1 || T_ACT_RW < 1 || RD_LAT < 1 || WR_LAT < 1) begin : g_bad_timing
      $error("nvm3p_seq: all gaps and latencies must be at least one clock");
   end

   seq_st_e          st_q;
   ca_opc_e          opc_q;
   ca_opc_e          issue_opc;
   logic [BA_W-1:0]  ba_q;
   logic             done_q;
   logic             pf_q;
   logic             wr_q;
   logic [ROW_W-1:0] row_q;
   logic [COL_W-1:0] col_q;
   logic [BA_W-1:0]  buf_q;
   logic             tmr_expired;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             finish;
   seq_st_e          st_next;

   // next-command decision
   always_comb begin
      issue_opc = OPC_NOP;
      finish    = 1'b0;
      st_next   = st_q;
      case (st_q)
         ST_IDLE: begin
            if (req_valid) begin
               if (req_hit && !req_op[1]) begin
                  issue_opc = req_op[0] ? OPC_WR : OPC_RD;
                  st_next   = ST_TAIL;
               end else begin
                  issue_opc = OPC_PRE;
                  st_next   = ST_PRE_WAIT;
               end
            end
         end
         ST_PRE_WAIT: begin
            if (tmr_expired) begin
               issue_opc = OPC_ACT;
               st_next   = ST_ACT_WAIT;
            end
         end
         ST_ACT_WAIT: begin
            if (tmr_expired) begin
               if (pf_q) begin
                  finish  = 1'b1;
                  st_next = ST_IDLE;
               end else begin
                  issue_opc = wr_q ? OPC_WR : OPC_RD;
                  st_next   = ST_TAIL;
               end
            end
         end
         default: begin
            if (tmr_expired) begin
               finish  = 1'b1;
               st_next = ST_IDLE;
            end
         end
      endcase
   end

   always_comb begin
      case (issue_opc)
         OPC_PRE: tmr_val = CNT_W'(T_PRE_ACT - 1);
         OPC_ACT: tmr_val = CNT_W'(T_ACT_RW - 1);
         OPC_RD:  tmr_val = CNT_W'(RD_LAT - 1);
         OPC_WR:  tmr_val = CNT_W'(WR_LAT - 1);
         default: tmr_val = '0;
      endcase
   end

   assign tmr_load = (issue_opc != OPC_NOP);

   nvm3p_gap_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         opc_q  <= OPC_NOP;
         ba_q   <= '0;
         done_q <= 1'b0;
         pf_q   <= 1'b0;
         wr_q   <= 1'b0;
         row_q  <= '0;
         col_q  <= '0;
         buf_q  <= '0;
      end else begin
         st_q   <= st_next;
         opc_q  <= issue_opc;
         done_q <= finish;
         if (st_q == ST_IDLE && req_valid) begin
            pf_q  <= req_op[1];
            wr_q  <= req_op[0];
            row_q <= req_row;
            col_q <= req_col;
            buf_q <= req_buf;
            ba_q  <= req_buf;
         end else if (issue_opc != OPC_NOP) begin
            ba_q <= buf_q;
         end else begin
            ba_q <= '0;
         end
      end
   end

   nvm3p_ca_encoder #(
      .ROW_W    (ROW_W),
      .ROW_LO_W (ROW_LO_W),
      .COL_W    (COL_W)
   ) u_enc (
      .opc  (opc_q),
      .row  (row_q),
      .col  (col_q),
      .rise (ca_rise),
      .fall (ca_fall)
   );

   assign ca_ba     = ba_q;
   assign done      = done_q;
   assign busy      = (st_q != ST_IDLE);
   assign req_ready = (st_q == ST_IDLE);

endmodule

// File: rtl/nvm3p_seq_chk.sv
`timescale 1ns/1ps
module nvm3p_seq_chk
   import nvm3p_pkg::*;
#(
   parameter int NUM_BUF   = 4,
   parameter int T_PRE_ACT = 3,
   parameter int T_ACT_RW  = 48,
   localparam int BA_W     = $clog2(NUM_BUF)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic [9:0]      ca_rise,
   input logic [9:0]      ca_fall,
   input logic [BA_W-1:0] ca_ba,
   input logic            done,
   input logic            busy
);

   localparam logic [15:0] SAT = 16'hFFFF;

   logic [2:0]  opc;
   logic [15:0] since_pre;
   logic [15:0] since_act;

   assign opc = ca_rise[9:7];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_pre <= SAT;
         since_act <= SAT;
      end else begin
         since_pre <= (opc == OPC_PRE) ? 16'd1 : ((since_pre == SAT) ? SAT : since_pre + 16'd1);
         since_act <= (opc == OPC_ACT) ? 16'd1 : ((since_act == SAT) ? SAT : since_act + 16'd1);
      end
   end

   AST_PRE_ACT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (opc == OPC_ACT) |-> (since_pre >= 16'(T_PRE_ACT))); // R4

   AST_ACT_RW_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (opc == OPC_RD || opc == OPC_WR) |-> (since_act >= 16'(T_ACT_RW))); // R5

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (opc == OPC_NOP) |-> (ca_rise == 10'd0 && ca_fall == 10'd0 && ca_ba == '0)); // R2

   AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (opc <= 3'd4)); // R2

   AST_ACCEPT_START: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (opc == OPC_PRE || opc == OPC_RD || opc == OPC_WR)); // R3

   AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (opc != OPC_NOP) |-> (busy && !req_ready)); // R9

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8

   AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && req_ready)); // R8

endmodule

bind nvm3p_seq nvm3p_seq_chk #(
   .NUM_BUF   (NUM_BUF),
   .T_PRE_ACT (T_PRE_ACT),
   .T_ACT_RW  (T_ACT_RW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .ca_rise   (ca_rise),
   .ca_fall   (ca_fall),
   .ca_ba     (ca_ba),
   .done      (done),
   .busy      (busy)
);

// File: tb/nvm3p_seq_bench.sv
`timescale 1ns/1ps
module nvm3p_seq_bench;

   localparam int BW  = 2;
   localparam int RWD = 20;
   localparam int LO  = 8;
   localparam int CW  = 5;
   localparam int TPA = 3;
   localparam int TAR = 48;
   localparam int RL  = 6;
   localparam int WL  = 3;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           req_valid = 1'b0;
   logic           req_ready;
   logic [1:0]     req_op = 2'b00;
   logic [RWD-1:0] req_row = '0;
   logic [CW-1:0]  req_col = '0;
   logic [BW-1:0]  req_buf = '0;
   logic           req_hit = 1'b0;
   logic [9:0]     ca_rise;
   logic [9:0]     ca_fall;
   logic [BW-1:0]  ca_ba;
   logic           done;
   logic           busy;

   int vectors = 0;
   int miscompares = 0;
   bit finished = 1'b0;

   logic [24:0] eq[$];
   string       tq[$];

   always #4 clk = ~clk;

   nvm3p_seq u_nvm3p_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_row(req_row), .req_col(req_col), .req_buf(req_buf),
      .req_hit(req_hit), .ca_rise(ca_rise), .ca_fall(ca_fall), .ca_ba(ca_ba),
      .done(done), .busy(busy)
   );

   // expected cycle: {code, payload, select, done, busy, ready}
   function automatic logic [24:0] mk(input logic [2:0] opc, input logic [16:0] pl,
                                      input logic [BW-1:0] b, input logic dn, input logic bsy);
      return {opc, pl, b, dn, bsy, ~bsy};
   endfunction

   task automatic push(input logic [24:0] e, input string tag);
      eq.push_back(e);
      tq.push_back(tag);
   endtask

   task automatic compare(input string deftag);
      logic [24:0] exp;
      logic [24:0] act;
      string       t;
      if (eq.size() > 0) begin
         exp = eq.pop_front();
         t   = tq.pop_front();
      end else begin
         exp = mk(3'd0, 17'd0, '0, 1'b0, 1'b0);
         t   = deftag;
      end
      act = {ca_rise, ca_fall, ca_ba, done, busy, req_ready};
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: got %h expected %h", t, act, exp);
      end
   endtask

   task automatic tick(input string deftag);
      @(negedge clk);
      compare(deftag);
   endtask

   // called at a negedge with the model queue empty
   task automatic do_req(input logic [1:0] op, input logic [RWD-1:0] row,
                         input logic [CW-1:0] col, input logic [BW-1:0] b,
                         input logic hit, input bit spam);
      logic       pf;
      logic [2:0] rwc;
      int         lat;
      int         n;
      pf  = op[1];
      rwc = op[0] ? 3'd4 : 3'd3;
      lat = op[0] ? WL : RL;
      req_valid = 1'b1;
      req_op = op; req_row = row; req_col = col; req_buf = b; req_hit = hit;
      if (hit && !pf) begin
         push(mk(rwc, 17'(col), b, 1'b0, 1'b1), "R6");
         for (int i = 1; i < lat; i++) push(mk(3'd0, 17'd0, '0, 1'b0, 1'b1), "R8");
         push(mk(3'd0, 17'd0, '0, 1'b1, 1'b0), "R8");
      end else begin
         push(mk(3'd1, 17'(row[RWD-1:LO]), b, 1'b0, 1'b1), spam ? "R9" : "R3 R10");
         for (int i = 1; i < TPA; i++) push(mk(3'd0, 17'd0, '0, 1'b0, 1'b1), "R4");
         push(mk(3'd2, 17'(row[LO-1:0]), b, 1'b0, 1'b1), spam ? "R9" : "R4 R10");
         for (int i = 1; i < TAR; i++) push(mk(3'd0, 17'd0, '0, 1'b0, 1'b1), "R5");
         if (pf) begin
            push(mk(3'd0, 17'd0, '0, 1'b1, 1'b0), "R7");
         end else begin
            push(mk(rwc, 17'(col), b, 1'b0, 1'b1), spam ? "R9" : "R5 R10");
            for (int i = 1; i < lat; i++) push(mk(3'd0, 17'd0, '0, 1'b0, 1'b1), "R8");
            push(mk(3'd0, 17'd0, '0, 1'b1, 1'b0), "R8");
         end
      end
      tick("R2");
      if (spam) begin
         // R9: conflicting request held while busy
         req_op = 2'b10; req_row = ~row; req_col = ~col; req_buf = ~b; req_hit = 1'b1;
      end else begin
         req_valid = 1'b0;
      end
      n = 0;
      while (eq.size() > 0) begin
         tick("R2");
         n++;
         if (n == 8) req_valid = 1'b0;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog: got hang expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) tick("R1");
      // R3 R4 R5 R8 R10: read miss
      do_req(2'b00, 20'hABCDE, 5'h13, 2'd1, 1'b0, 1'b0);
      // R8: write miss, back to back with the done cycle
      do_req(2'b01, 20'h00F0F, 5'h1F, 2'd3, 1'b0, 1'b0);
      repeat (4) tick("R2");
      // R6: read hit and write hit
      do_req(2'b00, 20'h12345, 5'h0A, 2'd2, 1'b1, 1'b0);
      do_req(2'b01, 20'hFFFFF, 5'h01, 2'd0, 1'b1, 1'b0);
      repeat (2) tick("R2");
      // R7: prefetch with hit hint set, and the 11 encoding
      do_req(2'b10, 20'h5A5A5, 5'h07, 2'd0, 1'b1, 1'b0);
      do_req(2'b11, 20'hFF001, 5'h1E, 2'd3, 1'b0, 1'b0);
      // R6 after prefetch: hit read straight away
      do_req(2'b00, 20'hFF001, 5'h04, 2'd3, 1'b1, 1'b0);
      // R9: request held during busy is ignored
      do_req(2'b01, 20'h80001, 5'h15, 2'd2, 1'b0, 1'b1);
      repeat (5) tick("R2");
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule